// File: doc/BRIEF.md
# Receiver PHY Power and Reset Handshake Controller

This block sits between a register file and a multi-lane receiver PHY complex. Software writes a two-bit power command and a reset-release bit. The block models how the complex responds. It reports a power status that catches up with the command after a fixed, parameterised latency. It raises a reset-done flag only when three things hold together: reset has been released, the complex is powered on, and the external sensor's high-speed clock has been seen running for a settle window. Software starts a power change and then polls the status until it matches the command. A shutdown commands power off first and asserts reset afterwards.

A control-clock enable gates the whole complex. While it is low, the status is held at off whatever the command says. A lane-enable mask is passed through to the lanes only while the complex is enabled and on. The usual setting for the mask is all ones, one bit per lane, regardless of how many lanes carry data.

Top module: `phy_pwr_handshake`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, pwrStatus reads off (0), resetDone is 0 and laneActive is all zeros.
- R2: The power codes are 0 for off, 1 for on and 2 for ultra-low-power. A command of 3 is treated as off, and pwrStatus never reads 3.
- R3: With ctrlClkEn high, a command that differs from the status leaves pwrStatus unchanged for STEP_LATENCY-1 clock edges. pwrStatus equals the command after edge STEP_LATENCY.
- R4: pwrStatus changes at most once per STEP_LATENCY-edge window. If the command changes while a step is pending, the wait is not restarted, and the status lands on the latest command when the window completes.
- R5: When ctrlClkEn is low, pwrStatus reads off one edge later and stays off whatever the command. Once ctrlClkEn is high again, the status follows the command with the R3 latency.
- R6: resetDone rises on exactly the SETTLE_CYCLES-th consecutive edge at which resetRelease, hsClkActive and ctrlClkEn are all high and pwrStatus is on. After SETTLE_CYCLES-1 such edges it is still low.
- R7: A single edge with hsClkActive low clears resetDone and restarts the settle count from zero.
- R8: While resetRelease is 0, resetDone stays 0 even when the high-speed clock is present and power is on.
- R9: On shutdown (command off, then reset asserted), resetDone reads 0 from the second edge after pwrStatus leaves on, and it stays 0.
- R10: laneActive equals laneEnable while ctrlClkEn is high and pwrStatus is on. It is all zeros in the off and ultra-low-power states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| pwrCmd | input | 2 | Requested power state (0 off, 1 on, 2 ultra-low-power) |
| resetRelease | input | 1 | 1 releases the PHY reset, 0 holds it |
| ctrlClkEn | input | 1 | Control clock enable for the complex |
| laneEnable | input | NUM_LANES | Lane enable mask |
| hsClkActive | input | 1 | High-speed clock activity detected on the clock lane |
| pwrStatus | output | 2 | Reported power state, same codes as pwrCmd |
| resetDone | output | 1 | 1 when PHY reset has completed, 0 while it is ongoing |
| laneActive | output | NUM_LANES | Lane enables actually applied to the complex |

## Verification
On every cycle, the assertions check the following. The status never shows the unused code. It falls to off one edge after the clock enable drops. A status change happens only when the step counter sits at its last count. Reset-done is high only when the previous edge saw release, clock activity and enable together. Lanes are driven only while the complex is on. The bench scenarios are needed for the exact edge counts: the step latency, an uninterrupted step across a mid-wait command change, the settle window and its restart after a clock gap, and the order of the shutdown sequence.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_ON   = 2'd1,
    PWR_ULPS = 2'd2
  } pwrState_e;

  typedef struct packed {
    logic      stepNow;
    logic      forceOff;
    logic      runEn;
    pwrState_e nextState;
  } ctrlStrobes_t;
endpackage

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int STEP_LATENCY = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   pwrCmd,
  input  logic         ctrlClkEn,
  input  logic         resetRelease,
  input  logic         hsClkActive,
  input  pwrState_e    pwrStatus,
  output ctrlStrobes_t strobes
);
  localparam int CntW = (STEP_LATENCY > 2) ? $clog2(STEP_LATENCY) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(STEP_LATENCY - 1);

  logic [CntW-1:0] stepCnt;
  pwrState_e targetState;
  logic mismatch;

  always_comb begin
    if (!ctrlClkEn) targetState = PWR_OFF;
    else begin
      case (pwrCmd)
        2'd1:    targetState = PWR_ON;
        2'd2:    targetState = PWR_ULPS;
        default: targetState = PWR_OFF;
      endcase
    end
  end

  assign mismatch = (targetState != pwrStatus);

  always_ff @(posedge clk) begin
    if (!rstN) stepCnt <= '0;
    else if (!ctrlClkEn || !mismatch) stepCnt <= '0;
    else if (stepCnt == CntLast) stepCnt <= '0;
    else stepCnt <= stepCnt + 1'b1;
  end

  always_comb begin
    strobes.forceOff  = !ctrlClkEn;
    strobes.stepNow   = ctrlClkEn && mismatch && (stepCnt == CntLast);
    strobes.nextState = targetState;
    strobes.runEn     = resetRelease && hsClkActive && ctrlClkEn && (pwrStatus == PWR_ON);
  end

  // R3: a status move while enabled only ever follows the last count of the wait
  assert_step_timing_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrStatus != $past(pwrStatus)) && $past(ctrlClkEn)) |-> ($past(stepCnt) == CntLast));
endmodule

// File: rtl/phy_pwr_datapath.sv
module phy_pwr_datapath
  import phy_pwr_pkg::*;
#(
  parameter int NUM_LANES     = 5,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [NUM_LANES-1:0] laneEnable,
  output pwrState_e            pwrStatus,
  output logic                 resetDone,
  output logic [NUM_LANES-1:0] laneActive
);
  localparam int RunW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [RunW-1:0] RunFull = RunW'(SETTLE_CYCLES);

  logic [RunW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) pwrStatus <= PWR_OFF;
    else if (strobes.forceOff) pwrStatus <= PWR_OFF;
    else if (strobes.stepNow) pwrStatus <= strobes.nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (!strobes.runEn) runCnt <= '0;
    else if (runCnt != RunFull) runCnt <= runCnt + 1'b1;
  end

  assign resetDone  = (runCnt == RunFull);
  assign laneActive = (pwrStatus == PWR_ON && !strobes.forceOff) ? laneEnable : '0;

  // R9: once the control withdraws its run strobe, reset-done reads ongoing
  assert_done_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.runEn) |-> !resetDone);
endmodule

// File: rtl/phy_pwr_handshake.sv
module phy_pwr_handshake
  import phy_pwr_pkg::*;
#(
  parameter int NUM_LANES     = 5,
  parameter int STEP_LATENCY  = 8,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           pwrCmd,
  input  logic                 resetRelease,
  input  logic                 ctrlClkEn,
  input  logic [NUM_LANES-1:0] laneEnable,
  input  logic                 hsClkActive,
  output logic [1:0]           pwrStatus,
  output logic                 resetDone,
  output logic [NUM_LANES-1:0] laneActive
);
  ctrlStrobes_t strobes;
  pwrState_e    statusQ;

  phy_pwr_ctrl #(.STEP_LATENCY(STEP_LATENCY)) ctrl_i (
    .clk(clk), .rstN(rstN), .pwrCmd(pwrCmd), .ctrlClkEn(ctrlClkEn),
    .resetRelease(resetRelease), .hsClkActive(hsClkActive),
    .pwrStatus(statusQ), .strobes(strobes)
  );

  phy_pwr_datapath #(.NUM_LANES(NUM_LANES), .SETTLE_CYCLES(SETTLE_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .laneEnable(laneEnable),
    .pwrStatus(statusQ), .resetDone(resetDone), .laneActive(laneActive)
  );

  assign pwrStatus = statusQ;

  assert_gated_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlClkEn |=> (pwrStatus == 2'd0));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    pwrStatus != 2'd3);

  assert_done_needs_clock_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetDone |-> $past(resetRelease && hsClkActive && ctrlClkEn));

  assert_lanes_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    (laneActive != '0) |-> (pwrStatus == 2'd1 && ctrlClkEn));
endmodule

// File: tb/phy_pwr_handshake_tb_top.sv
module phy_pwr_handshake_tb_top;
  localparam int LANES  = 5;
  localparam int LAT    = 8;
  localparam int SETTLE = 16;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] pwrCmd;
  logic resetRelease, ctrlClkEn, hsClkActive;
  logic [LANES-1:0] laneEnable;
  logic [1:0] pwrStatus;
  logic resetDone;
  logic [LANES-1:0] laneActive;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  phy_pwr_handshake #(.NUM_LANES(LANES), .STEP_LATENCY(LAT), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .pwrCmd(pwrCmd), .resetRelease(resetRelease),
    .ctrlClkEn(ctrlClkEn), .laneEnable(laneEnable), .hsClkActive(hsClkActive),
    .pwrStatus(pwrStatus), .resetDone(resetDone), .laneActive(laneActive)
  );

  // each entry: {command, expected status after the step}
  localparam logic [3:0] PowerTable [8] = '{
    {2'd1, 2'd1}, {2'd2, 2'd2}, {2'd1, 2'd1}, {2'd0, 2'd0},
    {2'd2, 2'd2}, {2'd0, 2'd0}, {2'd1, 2'd1}, {2'd3, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] prevStatus;
    rstN = 1'b0; pwrCmd = 2'd0; resetRelease = 1'b0; ctrlClkEn = 1'b0;
    hsClkActive = 1'b0; laneEnable = '1;
    tick(3);
    chk("R1 status", pwrStatus, 0);
    chk("R1 done", resetDone, 0);
    chk("R1 lanes", laneActive, 0);
    rstN = 1'b1; ctrlClkEn = 1'b1;
    tick(1);
    chk("R1 status after release", pwrStatus, 0);

    // R2 R3: table of power steps
    prevStatus = 2'd0;
    for (int i = 0; i < 8; i++) begin
      pwrCmd = PowerTable[i][3:2];
      tick(LAT - 1);
      chk("R3 held before latency", pwrStatus, prevStatus);
      tick(1);
      chk("R2 R3 status after latency", pwrStatus, PowerTable[i][1:0]);
      prevStatus = PowerTable[i][1:0];
    end

    // R4: command change mid-wait does not restart the window
    pwrCmd = 2'd1;
    tick(3);
    pwrCmd = 2'd2;
    tick(4);
    chk("R4 held through window", pwrStatus, 0);
    tick(1);
    chk("R4 lands on latest command", pwrStatus, 2);
    pwrCmd = 2'd1;
    tick(LAT);
    chk("R3 ulps to on", pwrStatus, 1);

    // R10: lanes pass through while on
    chk("R10 all lanes", laneActive, 5'h1F);
    laneEnable = 5'h0B;
    #1;
    chk("R10 partial mask", laneActive, 5'h0B);
    laneEnable = '1;

    // R8: reset held keeps done low
    hsClkActive = 1'b1;
    tick(30);
    chk("R8 done while reset held", resetDone, 0);

    // R6: settle window
    resetRelease = 1'b1;
    tick(SETTLE - 1);
    chk("R6 done before window", resetDone, 0);
    tick(1);
    chk("R6 done at window", resetDone, 1);

    // R7: clock gap restarts count
    hsClkActive = 1'b0;
    tick(1);
    chk("R7 done cleared by gap", resetDone, 0);
    hsClkActive = 1'b1;
    tick(SETTLE - 1);
    chk("R7 count restarted", resetDone, 0);
    tick(1);
    chk("R7 done after new window", resetDone, 1);

    // R9: shutdown
    pwrCmd = 2'd0;
    tick(LAT - 1);
    chk("R9 still on", pwrStatus, 1);
    chk("R9 done before power falls", resetDone, 1);
    tick(1);
    chk("R9 status off", pwrStatus, 0);
    tick(1);
    chk("R9 done ongoing", resetDone, 0);
    resetRelease = 1'b0;
    tick(5);
    chk("R9 done stays ongoing", resetDone, 0);

    // R5: clock enable gating
    pwrCmd = 2'd1;
    tick(LAT);
    chk("R5 on before gating", pwrStatus, 1);
    ctrlClkEn = 1'b0;
    #1;
    chk("R10 lanes off when gated", laneActive, 0);
    tick(1);
    chk("R5 off one edge after gating", pwrStatus, 0);
    tick(20);
    chk("R5 stays off", pwrStatus, 0);
    ctrlClkEn = 1'b1;
    tick(LAT - 1);
    chk("R5 held after enable", pwrStatus, 0);
    tick(1);
    chk("R5 follows after enable", pwrStatus, 1);

    // R10: ultra-low-power has no lanes
    pwrCmd = 2'd2;
    tick(LAT);
    chk("R2 ulps status", pwrStatus, 2);
    chk("R10 lanes off in ulps", laneActive, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule